// File: doc/BRIEF.md
# Status LED Blink Override

This block takes over one GPIO pin of a two-port GPIO bank and uses it to drive a status LED. A single 8-bit configuration byte, loaded through a write strobe, says whether the function is on. It also chooses which pin is taken over, by a port bit and a pin index. A three-bit code sets what the pin does: drive low, release, or blink with 50% duty at one of three slow rates.

The blink timebase is a prescaler parameterised by the system clock frequency. Its half-second tick feeds a small phase counter, and the 1 Hz, 0.5 Hz and 0.25 Hz waveforms are taken from that counter's bits. Each configuration write restarts the timebase, so every blink pattern begins low.

The outputs are meant for the pad multiplexer:
- a one-hot mask of the pin being overridden;
- the level to present on that pin;
- an output-enable.

While the mask bit is set, the pad logic must use these values and ignore the pin's own direction and data settings. A released open-drain pin is reported with the enable low. A released push-pull pin is reported as driven high.

Top module: `led_ovr_top`

## Requirements
- R1: Reset (synchronous, active low) clears the configuration byte to 0x00; while reset is applied and afterwards until a write, `ovr_mask` is zero and `ovr_val` and `ovr_oe` are 0.
- R2: With bit 7 of the configuration (enable) at 0, `ovr_mask` is zero and `ovr_val`/`ovr_oe` are 0, whatever bits 6..0 hold.
- R3: With enable set, bit 3 = 0 selects port 1 and pin index bits 2..0 in 0..6 set exactly mask bit `index`. Bit 3 = 1 selects port 2, and index 3..5 sets exactly mask bit `8 + index`.
- R4: An index outside the legal range of the chosen port (7 on port 1; 0..2, 6 or 7 on port 2) gives a zero mask with `ovr_val` and `ovr_oe` at 0.
- R5: Code bits 6..4 = 111 releases the pin: `ovr_val` = 1, and `ovr_oe` = 0 when the pin is marked open-drain in `OD_MASK`, 1 when it is push-pull.
- R6: Codes 000, 001, 010 and 011 drive the selected pin low: `ovr_oe` = 1 and `ovr_val` = 0.
- R7: Code 110 blinks at 1 Hz: `ovr_oe` = 1, and `ovr_val` is low for the first CLK_HZ/2 cycles after the write and then toggles every CLK_HZ/2 cycles.
- R8: Code 101 toggles every CLK_HZ cycles (0.5 Hz), and code 100 toggles every 2*CLK_HZ cycles (0.25 Hz). Both start low after the write.
- R9: Every configuration write restarts the timebase, so a blink code written while a blink is high returns `ovr_val` to 0 at once and rises again CLK_HZ/2 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle |
| cfg_wdata | input | 8 | Configuration byte: [7] enable, [6:4] code, [3] port, [2:0] pin index |
| ovr_mask | output | P1_W+P2_W | One-hot override mask; port 1 pins in the low P1_W bits, port 2 above them |
| ovr_val | output | 1 | Level for the overridden pin |
| ovr_oe | output | 1 | Output-enable for the overridden pin |

## Verification
The configuration register and the timebase load on the same edge that samples `cfg_wr`. The outputs are combinational from those registers, so every static result (mask, drive-low, release, out-of-range index, enable off) is due in the cycle right after that edge. The bench samples it one time unit past the edge. A blink level is due `floor(k / (CLK_HZ/2))` half-periods after the write, where k counts rising edges after the write edge. The bench walks k edge by edge and computes the expected bit from k alone. The bench uses CLK_HZ = 8 so that the 0.25 Hz pattern fits in 32 cycles.

// File: rtl/led_ovr_pkg.sv
// Shared types and code values for the LED override block.
// Assumes the configuration byte layout: [7] enable, [6:4] code,
// [3] port, [2:0] pin index.
package led_ovr_pkg;

    typedef struct packed {
        logic       en;
        logic [2:0] code;
        logic       port;
        logic [2:0] pin;
    } led_cfg_t;

    localparam logic [2:0] CODE_RELEASE = 3'b111;
    localparam logic [2:0] CODE_BLINK_1 = 3'b110;
    localparam logic [2:0] CODE_BLINK_2 = 3'b101;
    localparam logic [2:0] CODE_BLINK_4 = 3'b100;

    localparam int PHASE_W = 3;

endpackage

// File: rtl/led_ovr_timebase.sv
// Blink timebase: a prescaler emits a tick every HALF clock cycles
// (half a second), and a phase counter counts those ticks. Phase bit n
// is a square wave with period 2^(n+1) half-seconds.
// Assumes CLK_HZ >= 2. A restart pulse clears both counters.
module led_ovr_timebase #(
    parameter int CLK_HZ = 33_000_000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            restart,
    output logic [led_ovr_pkg::PHASE_W-1:0] phase
);
    localparam int HALF  = (CLK_HZ / 2 > 0) ? CLK_HZ / 2 : 1;
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt;

    // Prescaler and phase counter, cleared by reset or a config write.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt   <= '0;
            phase <= '0;
        end else if (cnt == CNT_LAST) begin
            cnt   <= '0;
            phase <= phase + 1'b1;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/led_ovr_pinsel.sv
// Pin decoder: turns port bit and pin index into a one-hot mask across
// both ports. Indexes outside a port's legal range give an empty mask.
// Also reports whether the chosen pin is open-drain.
module led_ovr_pinsel #(
    parameter int                 P1_W     = 8,
    parameter int                 P2_W     = 7,
    parameter int                 P1_MAX   = 6,
    parameter int                 P2_MIN   = 3,
    parameter int                 P2_MAX   = 5,
    parameter logic [P1_W+P2_W-1:0] OD_MASK = '1
) (
    input  logic                 port,
    input  logic [2:0]           pin,
    output logic [P1_W+P2_W-1:0] mask,
    output logic                 is_od
);
    // Port 1 bits: legal only up to P1_MAX.
    for (genvar i = 0; i < P1_W; i++) begin : g_p1
        if (i <= P1_MAX && i < 8) begin : g_legal
            assign mask[i] = !port && (pin == 3'(i));
        end else begin : g_off
            assign mask[i] = 1'b0;
        end
    end

    // Port 2 bits: legal only in P2_MIN..P2_MAX.
    for (genvar j = 0; j < P2_W; j++) begin : g_p2
        if (j >= P2_MIN && j <= P2_MAX && j < 8) begin : g_legal
            assign mask[P1_W+j] = port && (pin == 3'(j));
        end else begin : g_off
            assign mask[P1_W+j] = 1'b0;
        end
    end

    // Open-drain flag of whichever pin is selected.
    assign is_od = |(mask & OD_MASK);

endmodule

// File: rtl/led_ovr_level.sv
// Level generator: maps the three-bit code and timebase phase to the
// pin level and output-enable. Unnamed codes drive low.
module led_ovr_level (
    input  logic [2:0]                      code,
    input  logic [led_ovr_pkg::PHASE_W-1:0] phase,
    input  logic                            is_od,
    output logic                            val,
    output logic                            oe
);
    import led_ovr_pkg::*;

    // Code decode; release depends on pad type.
    always_comb begin
        oe  = 1'b1;
        val = 1'b0;
        case (code)
            CODE_RELEASE: begin
                val = 1'b1;
                oe  = !is_od;
            end
            CODE_BLINK_1: val = phase[0];
            CODE_BLINK_2: val = phase[1];
            CODE_BLINK_4: val = phase[2];
            default:      val = 1'b0;
        endcase
    end

endmodule

// File: rtl/led_ovr_top.sv
// LED override top: holds the configuration byte and gates the decoded
// pin mask and level with the enable bit. Outputs are combinational from
// registers, valid the cycle after a write. Synchronous active-low reset.
module led_ovr_top #(
    parameter int                   CLK_HZ  = 33_000_000,
    parameter int                   P1_W    = 8,
    parameter int                   P2_W    = 7,
    parameter int                   P1_MAX  = 6,
    parameter int                   P2_MIN  = 3,
    parameter int                   P2_MAX  = 5,
    parameter logic [P1_W+P2_W-1:0] OD_MASK = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [7:0]           cfg_wdata,
    output logic [P1_W+P2_W-1:0] ovr_mask,
    output logic                 ovr_val,
    output logic                 ovr_oe
);
    import led_ovr_pkg::*;

    localparam int MASK_W = P1_W + P2_W;

    led_cfg_t               cfg;
    logic [PHASE_W-1:0]     phase;
    logic [MASK_W-1:0]      pin_mask;
    logic                   pin_od;
    logic                   lvl_val;
    logic                   lvl_oe;
    logic                   active;

    // Configuration register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= '0;
        else if (cfg_wr) cfg <= led_cfg_t'(cfg_wdata);
    end

    led_ovr_timebase #(.CLK_HZ(CLK_HZ)) i_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_wr),
        .phase   (phase)
    );

    led_ovr_pinsel #(
        .P1_W(P1_W), .P2_W(P2_W), .P1_MAX(P1_MAX),
        .P2_MIN(P2_MIN), .P2_MAX(P2_MAX), .OD_MASK(OD_MASK)
    ) i_pinsel (
        .port  (cfg.port),
        .pin   (cfg.pin),
        .mask  (pin_mask),
        .is_od (pin_od)
    );

    led_ovr_level i_level (
        .code  (cfg.code),
        .phase (phase),
        .is_od (pin_od),
        .val   (lvl_val),
        .oe    (lvl_oe)
    );

    // Gate everything with enable and a legal pin.
    assign active   = cfg.en && (|pin_mask);
    assign ovr_mask = active ? pin_mask : '0;
    assign ovr_val  = active && lvl_val;
    assign ovr_oe   = active && lvl_oe;

endmodule

// File: rtl/led_ovr_checker.sv
// Property checker for led_ovr_top, attached by bind below.
module led_ovr_checker #(
    parameter int MASK_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              wr_en,
    input logic [2:0]        wr_code,
    input logic [MASK_W-1:0] ovr_mask,
    input logic              ovr_val,
    input logic              ovr_oe
);
    // At most one pin overridden.
    assert_mask_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ovr_mask));

    // Writing with enable clear leaves no override.
    assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !wr_en) |=> (ovr_mask == '0));

    // No pin selected means no drive.
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_mask == '0) |-> (!ovr_val && !ovr_oe));

    // A released pin never shows a low level.
    assert_release_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_mask != '0 && !ovr_oe) |-> ovr_val);

    // Any non-release write starts the pin low.
    assert_restart_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && wr_code != 3'b111) |=> !ovr_val);

endmodule

bind led_ovr_top led_ovr_checker #(.MASK_W(P1_W + P2_W)) i_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .wr_en    (cfg_wdata[7]),
    .wr_code  (cfg_wdata[6:4]),
    .ovr_mask (ovr_mask),
    .ovr_val  (ovr_val),
    .ovr_oe   (ovr_oe)
);

// File: tb/test_led_ovr_top.sv
module test_led_ovr_top;
    localparam int CLK_PERIOD = 10;
    localparam int HZ         = 8;
    localparam int HALF       = HZ / 2;
    localparam logic [14:0] ODM = 15'h7FFB; // pin 2 of port 1 is push-pull
    localparam int NV = 12;

    // Static vectors: config byte, expected mask, value, enable.
    localparam logic [7:0]  V_CFG  [NV] = '{8'h00, 8'h7F, 8'h80, 8'h96, 8'hBB, 8'hF5,
                                            8'hF2, 8'hFC, 8'h87, 8'h8A, 8'h8E, 8'hED};
    localparam logic [14:0] V_MASK [NV] = '{15'h0000, 15'h0000, 15'h0001, 15'h0040,
                                            15'h0800, 15'h0020, 15'h0004, 15'h1000,
                                            15'h0000, 15'h0000, 15'h0000, 15'h2000};
    localparam logic [NV-1:0] V_VAL = 12'b0000_1110_0000; // index 0 is LSB
    localparam logic [NV-1:0] V_OE  = 12'b1000_0101_1100;
    localparam string V_REQ [NV] = '{"R2", "R2", "R3", "R6", "R6", "R5",
                                     "R5", "R5", "R4", "R4", "R4", "R7"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [14:0] ovr_mask;
    logic        ovr_val;
    logic        ovr_oe;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    led_ovr_top #(.CLK_HZ(HZ), .OD_MASK(ODM)) i_led_ovr_top (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .ovr_mask(ovr_mask), .ovr_val(ovr_val), .ovr_oe(ovr_oe)
    );

    task automatic check(input string req, input logic [14:0] m, input logic v, input logic e);
        checks++;
        if (ovr_mask !== m || ovr_val !== v || ovr_oe !== e) begin
            errors++;
            $display("FAIL %s: mask=%h val=%b oe=%b expected mask=%h val=%b oe=%b",
                     req, ovr_mask, ovr_val, ovr_oe, m, v, e);
        end
    endtask

    // Write one byte; returns 1 time unit after the loading edge.
    task automatic write_cfg(input logic [7:0] b);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = b;
        @(posedge clk);
        #1;
        cfg_wr = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) step();
        check("R1", 15'h0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        check("R1", 15'h0, 1'b0, 1'b0);

        // Vector table walk
        for (int n = 0; n < NV; n++) begin
            write_cfg(V_CFG[n]);
            check(V_REQ[n], V_MASK[n], V_VAL[n], V_OE[n]);
        end

        // R7: 1 Hz blink on port 1 pin 1
        write_cfg(8'hE1);
        for (int k = 0; k < 16; k++) begin
            check("R7", 15'h0002, 1'((k / HALF) & 1), 1'b1);
            step();
        end

        // R8: 0.5 Hz blink on port 2 pin 4
        write_cfg(8'hDC);
        for (int k = 0; k < 24; k++) begin
            check("R8", 15'h1000, 1'(((k / HALF) >> 1) & 1), 1'b1);
            step();
        end

        // R8: 0.25 Hz blink on port 1 pin 0
        write_cfg(8'hC0);
        for (int k = 0; k < 40; k++) begin
            check("R8", 15'h0001, 1'(((k / HALF) >> 2) & 1), 1'b1);
            step();
        end

        // R9: rewrite during high phase restarts low
        write_cfg(8'hE1);
        repeat (HALF + 2) step();
        check("R9", 15'h0002, 1'b1, 1'b1);
        write_cfg(8'hE1);
        check("R9", 15'h0002, 1'b0, 1'b1);
        repeat (HALF - 1) step();
        check("R9", 15'h0002, 1'b0, 1'b1);
        step();
        check("R9", 15'h0002, 1'b1, 1'b1);

        // R2: disabling mid-blink drops the override
        write_cfg(8'h61);
        check("R2", 15'h0, 1'b0, 1'b0);
        repeat (HALF + 1) step();
        check("R2", 15'h0, 1'b0, 1'b0);

        // R6: code 010 drives low on port 2 pin 5
        write_cfg(8'hAD);
        check("R6", 15'h2000, 1'b0, 1'b1);

        // R1: reset during release clears the configuration
        write_cfg(8'hF2);
        check("R5", 15'h0004, 1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        step();
        check("R1", 15'h0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) step();
        check("R1", 15'h0, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule